// File: doc/BRIEF.md
# Two-Way Set-Associative Byte Cache

This block is a byte-addressed cache that sits between a processor request port and a main-memory port. Each line holds four bytes, and each set holds two lines. The processor issues single-byte reads and writes with a valid/ready handshake. A read or write that hits in the cache completes one cycle after it is accepted. A miss fetches the whole line from memory through a request/acknowledge handshake. If the line chosen for eviction was modified, it is first written back to memory.

Two static control inputs set the behaviour at run time:

- `cfg_disable` sends every access straight to memory.
- `cfg_wthru` selects write-through in place of write-back.

Two single-cycle command inputs maintain the contents:

- `cmd_inval` discards everything.
- `cmd_flush` walks every set, writes back the modified lines, and then discards them.

Both commands end with a single-cycle `cmd_done` pulse.

The geometry is set by `ADDR_W` and `SET_W`. The tag width is `ADDR_W - SET_W - 2`. A 24-bit address with 13 set bits gives a 9-bit tag.

Top module: `cache2w`

## Requirements
- R1: The byte address splits into three fields, from high to low bits:
  - the tag, in the upper `ADDR_W-SET_W-2` bits;
  - the set index, in bits `[SET_W+1:2]`;
  - the byte offset, in bits `[1:0]`.
  Two lines with the same set index and different tags can reside in the cache together, one in each way.
- R2: A read that hits a valid line with a matching tag returns the stored byte on `cpu_rdata`, with `cpu_resp` high in the cycle after acceptance. It causes no memory transaction.
- R3: On a miss, the line is replaced in this order:
  - the first invalid way, with way 0 preferred;
  - otherwise the way that is not marked most recently used in that set.
  Every hit or fill marks the referenced way as most recently used.
- R4: In write-back mode (`cfg_wthru`=0), a write hit changes only the cached byte and marks the line modified. Memory is not touched.
- R5: Before a miss refills a victim that is valid and modified, the victim line is written to memory as a full line (`mem_wstrb`=4'hF). A clean victim is not written back.
- R6: In write-through mode (`cfg_wthru`=1), every write issues one memory write of that byte (`mem_wstrb` = 1 shifted left by the byte offset). A write hit also updates the cached byte. A write miss does not allocate a line.
- R7: With `cfg_disable`=1, every read fetches the line from memory and every write issues a byte write. The cache contents and the recently-used marks are left unchanged.
- R8: When `cmd_inval` is accepted, every line becomes invalid in one cycle without any memory write. `cmd_done` pulses in the next cycle.
- R9: When `cmd_flush` is accepted, the block does the following:
  - writes every valid modified line back to memory;
  - leaves all lines invalid;
  - pulses `cmd_done` once, after the last set is done.
- R10: A read miss loads the full line from memory. The requested byte is returned with `cpu_resp` in the cycle after the fill acknowledge, which is the cycle in which the line is installed.
- R11: In write-back mode, a write miss fetches the line, merges the written byte into it, and installs it marked modified.
- R12: After reset, the cache is in this state:
  - all lines are invalid and all recently-used marks are 0;
  - `cpu_ready` is high and `mem_req` is low.
  `cpu_ready` stays low while a miss, write-back, memory operation or flush is in progress.
- R13: `mem_req`, `mem_we`, `mem_addr`, `mem_wstrb` and `mem_wdata` are held stable until the cycle in which `mem_ack` is high. `mem_addr` is a line address: the tag followed by the set index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_disable | input | 1 | 1: bypass the cache for every access |
| cfg_wthru | input | 1 | 1: write-through, 0: write-back |
| cmd_inval | input | 1 | Request to invalidate all lines (sampled while idle) |
| cmd_flush | input | 1 | Request to write back dirty lines, then invalidate |
| cmd_done | output | 1 | One-cycle pulse when a command finishes |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Block can accept a request or command |
| cpu_we | input | 1 | 1: write, 0: read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_resp | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read byte, valid with cpu_resp |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1: memory write |
| mem_addr | output | ADDR_W-2 | Line address |
| mem_wstrb | output | 4 | Byte enables for a write |
| mem_wdata | output | 32 | Write line |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | 32 | Read line |

## Verification
The bench sweeps every byte of a four-set cache in several orders and modes, and predicts the data, fills and write-backs for every access from a small model of its own. It targets these corner cases:

- **Three tags competing for one set.** A design with the recently-used mark inverted, or never updated, evicts the line that is about to be used. This shows up as an extra memory read on the next access.
- **Write hits in both modes.** A design that leaks write-back hits to memory, or drops write-through writes, produces the wrong write count. It also leaves the memory byte wrong.
- **Flush over dirty lines and discard by invalidate.** A design that skips the dirty check loses modified data or writes clean lines. A design that ends the walk early leaves stale lines that hit afterwards.
- **Bypass while valid lines are present.** A design that allocates during bypass turns a later expected hit into a miss.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;

    localparam int OFF_W  = 2;
    localparam int LINE_W = 32;
    localparam int WAYS   = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WBACK,
        S_FILL,
        S_MEMOP,
        S_FSCAN,
        S_FWB
    } ctl_state_e;

    typedef struct packed {
        logic valid;
        logic dirty;
    } line_flags_t;

    function automatic logic [7:0] line_byte(input logic [LINE_W-1:0] ln, input logic [OFF_W-1:0] off);
        return ln[off*8 +: 8];
    endfunction

    function automatic logic [LINE_W-1:0] line_merge(input logic [LINE_W-1:0] ln,
                                                     input logic [OFF_W-1:0] off,
                                                     input logic [7:0] b);
        logic [LINE_W-1:0] r;
        r = ln;
        r[off*8 +: 8] = b;
        return r;
    endfunction

    function automatic logic [3:0] byte_strobe(input logic [OFF_W-1:0] off);
        return 4'b0001 << off;
    endfunction

    // invalid way first (way 0 preferred), else the way not most recently used
    function automatic logic pick_victim(input line_flags_t f0, input line_flags_t f1, input logic mru);
        if (!f0.valid)      return 1'b0;
        else if (!f1.valid) return 1'b1;
        else                return ~mru;
    endfunction

endpackage

// File: rtl/cache_way.sv
module cache_way
    import cache2w_pkg::*;
#(
    parameter int TAG_W = 12,
    parameter int SET_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inval_all,
    input  logic [SET_W-1:0]  rd_set,
    output logic [TAG_W-1:0]  rd_tag,
    output line_flags_t       rd_flags,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [TAG_W-1:0]  wr_tag,
    input  line_flags_t       wr_flags,
    input  logic [LINE_W-1:0] wr_line
);
    localparam int SETS = 1 << SET_W;

    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [LINE_W-1:0] data_q [SETS];
    line_flags_t       flag_q [SETS];

    assign rd_tag   = tag_q[rd_set];
    assign rd_line  = data_q[rd_set];
    assign rd_flags = flag_q[rd_set];

    always_ff @(posedge clk) begin
        if (rst || inval_all) begin
            for (int i = 0; i < SETS; i++) flag_q[i] <= '0;
        end else if (wr_en) begin
            flag_q[wr_set] <= wr_flags;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !inval_all) begin
            tag_q[wr_set]  <= wr_tag;
            data_q[wr_set] <= wr_line;
        end
    end

    logic any_valid;
    always_comb begin
        any_valid = 1'b0;
        for (int i = 0; i < SETS; i++) any_valid = any_valid | flag_q[i].valid;
    end

    a_r8_inval_clears: assert property (@(posedge clk) disable iff (rst)
        inval_all |=> !any_valid);

    a_r12_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !any_valid);

endmodule

// File: rtl/cache_use.sv
module cache_use #(
    parameter int SET_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] rd_set,
    output logic             rd_mru,
    input  logic             touch_en,
    input  logic [SET_W-1:0] touch_set,
    input  logic             touch_way
);
    localparam int SETS = 1 << SET_W;

    logic [SETS-1:0] mru_q;

    assign rd_mru = mru_q[rd_set];

    always_ff @(posedge clk) begin
        if (rst)           mru_q <= '0;
        else if (touch_en) mru_q[touch_set] <= touch_way;
    end

    a_r3_touch_marks: assert property (@(posedge clk) disable iff (rst)
        touch_en |=> mru_q[$past(touch_set)] == $past(touch_way));

endmodule

// File: rtl/cache2w.sv
module cache2w
    import cache2w_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int SET_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_disable,
    input  logic                    cfg_wthru,
    input  logic                    cmd_inval,
    input  logic                    cmd_flush,
    output logic                    cmd_done,
    input  logic                    cpu_valid,
    output logic                    cpu_ready,
    input  logic                    cpu_we,
    input  logic [ADDR_W-1:0]       cpu_addr,
    input  logic [7:0]              cpu_wdata,
    output logic                    cpu_resp,
    output logic [7:0]              cpu_rdata,
    output logic                    mem_req,
    output logic                    mem_we,
    output logic [ADDR_W-OFF_W-1:0] mem_addr,
    output logic [3:0]              mem_wstrb,
    output logic [LINE_W-1:0]       mem_wdata,
    input  logic                    mem_ack,
    input  logic [LINE_W-1:0]       mem_rdata
);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;

    ctl_state_e st;

    logic [ADDR_W-1:0] rq_addr;
    logic              rq_we;
    logic [7:0]        rq_wdata;
    logic              vic_q;
    logic [SET_W-1:0]  fl_set;
    logic              fl_way;

    logic [TAG_W-1:0]  c_tag, r_tag, look_tag;
    logic [SET_W-1:0]  c_set, r_set, look_set;
    logic [OFF_W-1:0]  c_off, r_off;

    assign c_tag = cpu_addr[ADDR_W-1 -: TAG_W];
    assign c_set = cpu_addr[OFF_W +: SET_W];
    assign c_off = cpu_addr[OFF_W-1:0];
    assign r_tag = rq_addr[ADDR_W-1 -: TAG_W];
    assign r_set = rq_addr[OFF_W +: SET_W];
    assign r_off = rq_addr[OFF_W-1:0];

    assign look_set = (st == S_IDLE) ? c_set :
                      (st == S_FSCAN || st == S_FWB) ? fl_set : r_set;
    assign look_tag = (st == S_IDLE) ? c_tag : r_tag;

    // way storage
    logic [TAG_W-1:0]  way_tag  [WAYS];
    line_flags_t       way_flags[WAYS];
    logic [LINE_W-1:0] way_line [WAYS];
    logic [WAYS-1:0]   wr_en;
    logic [TAG_W-1:0]  wr_tag;
    line_flags_t       wr_flags;
    logic [LINE_W-1:0] wr_line;
    logic              inval_all;
    logic [WAYS-1:0]   hit_way;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        cache_way #(.TAG_W(TAG_W), .SET_W(SET_W)) u_way (
            .clk      (clk),
            .rst      (rst),
            .inval_all(inval_all),
            .rd_set   (look_set),
            .rd_tag   (way_tag[w]),
            .rd_flags (way_flags[w]),
            .rd_line  (way_line[w]),
            .wr_en    (wr_en[w]),
            .wr_set   (look_set),
            .wr_tag   (wr_tag),
            .wr_flags (wr_flags),
            .wr_line  (wr_line)
        );
        assign hit_way[w] = way_flags[w].valid && (way_tag[w] == look_tag);
    end

    logic mru, touch_en, touch_way;

    cache_use #(.SET_W(SET_W)) u_use (
        .clk      (clk),
        .rst      (rst),
        .rd_set   (look_set),
        .rd_mru   (mru),
        .touch_en (touch_en),
        .touch_set(look_set),
        .touch_way(touch_way)
    );

    logic hit, hsel, victim, scan_dirty, accept;
    assign hit        = |hit_way;
    assign hsel       = hit_way[1];
    assign victim     = pick_victim(way_flags[0], way_flags[1], mru);
    assign scan_dirty = way_flags[fl_way].valid && way_flags[fl_way].dirty;
    assign cpu_ready  = (st == S_IDLE) && !cmd_inval && !cmd_flush;
    assign accept     = cpu_valid && cpu_ready;

    // array write port and recently-used update
    always_comb begin
        wr_en      = '0;
        wr_tag     = look_tag;
        wr_flags   = '0;
        wr_line    = '0;
        touch_en   = 1'b0;
        touch_way  = 1'b0;
        inval_all  = (st == S_IDLE) && cmd_inval;
        case (st)
            S_IDLE: begin
                if (accept && !cfg_disable && hit) begin
                    touch_en  = 1'b1;
                    touch_way = hsel;
                    if (cpu_we) begin
                        wr_en[hsel]    = 1'b1;
                        wr_tag         = c_tag;
                        wr_flags.valid = 1'b1;
                        wr_flags.dirty = cfg_wthru ? way_flags[hsel].dirty : 1'b1;
                        wr_line        = line_merge(way_line[hsel], c_off, cpu_wdata);
                    end
                end
            end
            S_FILL: begin
                if (mem_ack) begin
                    wr_en[vic_q]   = 1'b1;
                    wr_tag         = r_tag;
                    wr_flags.valid = 1'b1;
                    wr_flags.dirty = rq_we;
                    wr_line        = rq_we ? line_merge(mem_rdata, r_off, rq_wdata) : mem_rdata;
                    touch_en       = 1'b1;
                    touch_way      = vic_q;
                end
            end
            S_FSCAN: begin
                if (fl_way && !scan_dirty) wr_en = '1;
            end
            S_FWB: begin
                if (mem_ack) begin
                    wr_en[fl_way]  = 1'b1;
                    wr_tag         = way_tag[fl_way];
                    wr_flags.valid = 1'b1;
                    wr_flags.dirty = 1'b0;
                    wr_line        = way_line[fl_way];
                end
            end
            default: ;
        endcase
    end

    // control sequence
    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            rq_addr   <= '0;
            rq_we     <= 1'b0;
            rq_wdata  <= '0;
            vic_q     <= 1'b0;
            fl_set    <= '0;
            fl_way    <= 1'b0;
            cmd_done  <= 1'b0;
            cpu_resp  <= 1'b0;
            cpu_rdata <= '0;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wstrb <= '0;
            mem_wdata <= '0;
        end else begin
            cpu_resp <= 1'b0;
            cmd_done <= 1'b0;
            if (mem_ack) mem_req <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (cmd_inval) begin
                        cmd_done <= 1'b1;
                    end else if (cmd_flush) begin
                        st     <= S_FSCAN;
                        fl_set <= '0;
                        fl_way <= 1'b0;
                    end else if (cpu_valid) begin
                        rq_addr  <= cpu_addr;
                        rq_we    <= cpu_we;
                        rq_wdata <= cpu_wdata;
                        if (cfg_disable || (cpu_we && cfg_wthru)) begin
                            mem_req   <= 1'b1;
                            mem_we    <= cpu_we;
                            mem_addr  <= {c_tag, c_set};
                            mem_wstrb <= cpu_we ? byte_strobe(c_off) : 4'h0;
                            mem_wdata <= {4{cpu_wdata}};
                            st        <= S_MEMOP;
                        end else if (hit) begin
                            cpu_resp  <= 1'b1;
                            cpu_rdata <= cpu_we ? cpu_wdata : line_byte(way_line[hsel], c_off);
                        end else begin
                            vic_q <= victim;
                            if (way_flags[victim].valid && way_flags[victim].dirty) begin
                                mem_req   <= 1'b1;
                                mem_we    <= 1'b1;
                                mem_addr  <= {way_tag[victim], c_set};
                                mem_wstrb <= 4'hF;
                                mem_wdata <= way_line[victim];
                                st        <= S_WBACK;
                            end else begin
                                mem_req   <= 1'b1;
                                mem_we    <= 1'b0;
                                mem_addr  <= {c_tag, c_set};
                                mem_wstrb <= 4'h0;
                                st        <= S_FILL;
                            end
                        end
                    end
                end
                S_WBACK: begin
                    if (mem_ack) begin
                        mem_req   <= 1'b1;
                        mem_we    <= 1'b0;
                        mem_addr  <= {r_tag, r_set};
                        mem_wstrb <= 4'h0;
                        st        <= S_FILL;
                    end
                end
                S_FILL: begin
                    if (mem_ack) begin
                        cpu_resp  <= 1'b1;
                        cpu_rdata <= rq_we ? rq_wdata : line_byte(mem_rdata, r_off);
                        st        <= S_IDLE;
                    end
                end
                S_MEMOP: begin
                    if (mem_ack) begin
                        cpu_resp  <= 1'b1;
                        cpu_rdata <= line_byte(mem_rdata, r_off);
                        st        <= S_IDLE;
                    end
                end
                S_FSCAN: begin
                    if (scan_dirty) begin
                        mem_req   <= 1'b1;
                        mem_we    <= 1'b1;
                        mem_addr  <= {way_tag[fl_way], fl_set};
                        mem_wstrb <= 4'hF;
                        mem_wdata <= way_line[fl_way];
                        st        <= S_FWB;
                    end else if (!fl_way) begin
                        fl_way <= 1'b1;
                    end else begin
                        fl_way <= 1'b0;
                        if (&fl_set) begin
                            cmd_done <= 1'b1;
                            st       <= S_IDLE;
                        end else begin
                            fl_set <= fl_set + 1'b1;
                        end
                    end
                end
                S_FWB: begin
                    if (mem_ack) st <= S_FSCAN;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    a_r13_req_held: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                && $stable(mem_wstrb) && $stable(mem_wdata));

    a_r12_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !cpu_ready);

    a_r2_hit_one_cycle: assert property (@(posedge clk) disable iff (rst)
        accept && !cpu_we && !cfg_disable && hit |=> cpu_resp && !mem_req);

    a_r4_wb_hit_quiet: assert property (@(posedge clk) disable iff (rst)
        accept && cpu_we && !cfg_wthru && !cfg_disable && hit |=> !mem_req && cpu_resp);

    a_r6_wt_goes_out: assert property (@(posedge clk) disable iff (rst)
        accept && cpu_we && cfg_wthru |=> mem_req && mem_we);

    a_r7_bypass_mem: assert property (@(posedge clk) disable iff (rst)
        accept && cfg_disable |=> mem_req && !touch_en);

    a_r10_resp_with_fill: assert property (@(posedge clk) disable iff (rst)
        st == S_FILL && mem_ack |=> cpu_resp);

    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        cmd_done |=> !cmd_done);

endmodule

// File: tb/sim_cache2w.sv
module sim_cache2w;
    localparam int CLK_NS = 10;
    localparam int AW = 8;
    localparam int SW = 2;
    localparam int NB = 1 << AW;
    localparam int NL = NB / 4;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_disable = 0, cfg_wthru = 0, cmd_inval = 0, cmd_flush = 0, cmd_done;
    logic cpu_valid = 0, cpu_ready, cpu_we = 0, cpu_resp;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0, cpu_rdata;
    logic mem_req, mem_we, mem_ack;
    logic [AW-3:0] mem_addr;
    logic [3:0] mem_wstrb;
    logic [31:0] mem_wdata, mem_rdata;

    always #(CLK_NS/2) clk = ~clk;

    cache2w #(.ADDR_W(AW), .SET_W(SW)) u0 (
        .clk(clk), .rst(rst), .cfg_disable(cfg_disable), .cfg_wthru(cfg_wthru),
        .cmd_inval(cmd_inval), .cmd_flush(cmd_flush), .cmd_done(cmd_done),
        .cpu_valid(cpu_valid), .cpu_ready(cpu_ready), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_resp(cpu_resp), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wstrb(mem_wstrb),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

    // memory model: acknowledge after a short wait
    logic [31:0] bmem [NL];
    int lat, nrd, nwr;
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 0; lat <= 0; nrd <= 0; nwr <= 0; mem_rdata <= '0;
            for (int i = 0; i < NB; i++) bmem[i/4][(i%4)*8 +: 8] <= 8'((i*37 + 11) & 255);
        end else if (mem_ack) begin
            mem_ack <= 0; lat <= 0;
        end else if (mem_req) begin
            if (lat == 2) begin
                mem_ack <= 1;
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_wstrb[b]) bmem[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
                    nwr <= nwr + 1;
                end else begin
                    mem_rdata <= bmem[mem_addr];
                    nrd <= nrd + 1;
                end
            end else lat <= lat + 1;
        end
    end

    int total = 0, bad = 0;
    logic [7:0] rmem [NB];
    bit m_val [4][2];
    bit m_dty [4][2];
    int m_tag [4][2];
    bit m_mru [4];

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input int a);
        return bmem[a/4][(a%4)*8 +: 8];
    endfunction

    task automatic acc(input bit we, input int a, input logic [7:0] wd);
        int s = (a >> 2) & 3, t = a >> 4, h = -1, erd = 0, ewr = 0, rd0, wr0, k;
        bit evict = 0, wbhit = 0;
        string tg;
        logic [7:0] old = mbyte(a), expv = rmem[a];
        if (cfg_disable) begin
            tg = "R7"; erd = we ? 0 : 1; ewr = we ? 1 : 0;
        end else begin
            for (int w = 0; w < 2; w++) if (m_val[s][w] && m_tag[s][w] == t) h = w;
            if (h >= 0) begin
                m_mru[s] = h[0];
                if (we && cfg_wthru) begin tg = "R6"; ewr = 1; end
                else if (we) begin tg = "R4"; m_dty[s][h] = 1; wbhit = 1; end
                else tg = "R2";
            end else if (we && cfg_wthru) begin
                tg = "R6"; ewr = 1;
            end else begin
                int v = !m_val[s][0] ? 0 : !m_val[s][1] ? 1 : (m_mru[s] ? 0 : 1);
                evict = m_val[s][v] && m_dty[s][v];
                ewr = evict ? 1 : 0; erd = 1;
                m_val[s][v] = 1; m_dty[s][v] = we; m_tag[s][v] = t; m_mru[s] = v[0];
                tg = we ? "R11" : "R10";
            end
        end
        if (we) rmem[a] = wd;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        rd0 = nrd; wr0 = nwr;
        cpu_valid = 1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = wd;
        @(negedge clk);
        cpu_valid = 0;
        k = 0;
        while (!cpu_resp && k < 200) begin @(negedge clk); k++; end
        chk(tg, "response seen", {31'b0, cpu_resp}, 1);
        if (!we) chk(tg, $sformatf("read data @%0h", a), cpu_rdata, expv);
        chk(tg, $sformatf("memory reads @%0h", a), nrd - rd0, erd);
        chk(evict ? "R5" : tg, $sformatf("memory writes @%0h", a), nwr - wr0, ewr);
        if (wbhit) chk("R4", "memory byte untouched", mbyte(a), old);
        if (we && (cfg_wthru || cfg_disable)) chk(tg, "memory byte written", mbyte(a), wd);
    endtask

    task automatic command(input bit fl);
        int k = 0, wr0, ndirty = 0;
        for (int s = 0; s < 4; s++) for (int w = 0; w < 2; w++) if (m_val[s][w] && m_dty[s][w]) ndirty++;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        wr0 = nwr;
        if (fl) cmd_flush = 1; else cmd_inval = 1;
        @(negedge clk);
        cmd_flush = 0; cmd_inval = 0;
        while (!cmd_done && k < 2000) begin @(negedge clk); k++; end
        chk(fl ? "R9" : "R8", "done pulse", {31'b0, cmd_done}, 1);
        if (!fl) chk("R8", "done one cycle after command", k, 0);
        chk(fl ? "R9" : "R8", "write-backs", nwr - wr0, fl ? ndirty : 0);
        if (fl) begin
            int mism = 0;
            for (int i = 0; i < NB; i++) if (mbyte(i) !== rmem[i]) mism++;
            chk("R9", "memory matches after flush", mism, 0);
        end else begin
            for (int i = 0; i < NB; i++) rmem[i] = mbyte(i);
        end
        for (int s = 0; s < 4; s++) for (int w = 0; w < 2; w++) begin m_val[s][w] = 0; m_dty[s][w] = 0; end
    endtask

    bit finished = 0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) rmem[i] = 8'((i*37 + 11) & 255);
        for (int s = 0; s < 4; s++) begin
            m_mru[s] = 0;
            for (int w = 0; w < 2; w++) begin m_val[s][w] = 0; m_dty[s][w] = 0; m_tag[s][w] = 0; end
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        chk("R12", "ready after reset", {31'b0, cpu_ready}, 1);
        chk("R12", "no memory request after reset", {31'b0, mem_req}, 0);
        chk("R12", "no response after reset", {31'b0, cpu_resp}, 0);
        chk("R9", "no done after reset", {31'b0, cmd_done}, 0);

        // R1 R2 R3 R10: write-back mode read sweeps
        for (int a = 0; a < NB; a++) acc(0, a, 0);
        for (int a = NB - 1; a >= 0; a--) acc(0, a, 0);
        // R4 R5 R11: write sweep then strided reads
        for (int a = 0; a < NB; a++) acc(1, a, 8'(a ^ 8'hA5));
        for (int a = 0; a < NB; a += 5) acc(0, a, 0);
        // R3: three tags on one set
        acc(0, 8'h04, 0); acc(0, 8'h14, 0); acc(0, 8'h04, 0); acc(0, 8'h24, 0);
        acc(0, 8'h06, 0); acc(1, 8'h15, 8'h3C); acc(0, 8'h27, 0); acc(0, 8'h15, 0);
        // R9: flush writes back dirty lines
        command(1);
        acc(0, 8'h15, 0);
        // R8: invalidate discards a dirty line
        acc(1, 8'h09, 8'hEE);
        command(0);
        acc(0, 8'h09, 0);
        // R6: write-through mode
        cfg_wthru = 1;
        for (int a = 0; a < NB; a += 3) acc(1, a, 8'(a + 8'h40));
        for (int a = 0; a < NB; a++) acc(0, a, 0);
        for (int a = 1; a < NB; a += 7) acc(1, a, 8'(a ^ 8'h0F));
        cfg_wthru = 0;
        command(1);
        // R7: bypass leaves cache contents alone
        acc(0, 8'h00, 0); acc(0, 8'h10, 0);
        cfg_disable = 1;
        acc(0, 8'h20, 0); acc(1, 8'h31, 8'h77); acc(0, 8'h31, 0); acc(0, 8'h00, 0);
        cfg_disable = 0;
        acc(0, 8'h00, 0); acc(0, 8'h10, 0); acc(0, 8'h31, 0);
        command(1);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule